// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a selected source tick stream into a square-wave baud clock using a programmable 16-bit down-counter. The source is either a synchronous enable strobe from the system clock domain or an external clock input. The external input is synchronized and edge-detected before use. The counter reloads a time constant after each terminal count. Each terminal count flips the output, so the half period is the time constant plus two source ticks.

Software programs the block through a byte-wide register port with one shared address. The 16-bit time constant is split into a low byte and a high byte. A control register holds the run bit and the source choice. A mode register selects a 1x, 16x, 32x or 64x serial clock multiplier, and the block emits one tick for each multiplied bit period. Each terminal count also produces a one-cycle zero strobe. When the timer interrupt enable is set, that strobe is latched into a status bit.

Top module: `baud_gen`

## Requirements
- R1: Register reads are combinational on `addr_i`. Address 12 returns the time-constant low byte and address 13 the high byte. Address 4 returns the full mode byte. Address 14 returns {6'b0, source, run}: bit0 is run and bit1 selects the strobe source. Address 15 returns only bit1, the timer enable, with all other bits zero. Address 0 returns the timer status in bit1.
- R2: With run set and the strobe source chosen (address 14 bit1 = 1), `baud_o` toggles once every TC+2 pulses of `pclk_en_i`, so the full period is 2·(TC+2) pulses.
- R3: With address 14 bit1 = 0, the source ticks are rising edges of `ext_clk_i`, taken after a two-stage synchronizer. One tick occurs per external rising edge.
- R4: While run is clear, the counter holds, `baud_o` does not change and `zero_o` stays low.
- R5: A write that sets run from 0 to 1 arms a reload. With `pclk_en_i` held high, `baud_o` first changes TC+2 clock cycles after the write edge.
- R6: A new time constant written mid-count does not shorten or lengthen the half period in progress. The new value is used from the next reload onward.
- R7: `zero_o` is a one-cycle pulse in the same cycle as every change of `baud_o`, and it is never high in two consecutive cycles.
- R8: The status bit (address 0 bit1) is set by a zero pulse while address 15 bit1 is 1. It then holds until a write to address 0 with bits[5:3] = 3'b010 clears it. With the enable clear, zero pulses do not set it.
- R9: `bit_tick_o` pulses once per N rising edges of `baud_o`. N is 1, 16, 32 or 64 for address 4 bits[7:6] = 00, 01, 10, 11.
- R10: After reset, all registers read 0 and `baud_o`, `zero_o`, `bit_tick_o` and `timer_stat_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register number for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| pclk_en_i | input | 1 | Synchronous source tick strobe |
| ext_clk_i | input | 1 | External source clock, asynchronous |
| baud_o | output | 1 | Square-wave baud clock |
| zero_o | output | 1 | Terminal-count pulse |
| bit_tick_o | output | 1 | One pulse per multiplied bit period |
| timer_stat_o | output | 1 | Latched timer status |

## Verification
The bench measures every half period in clock cycles. A counter that skips the reload tick would give TC+1 instead of TC+2, and one that reloads without a pause would drift by one tick per half period. It rewrites the time constant just after a reload. A design that loads the new value straight into the counter would show a wrong length for the half period already under way. It also times the first edge after enabling, catching an off-by-one in the arming path. It stops the counter mid-run, checks that the status latch ignores zero pulses when its enable is off, and checks that each multiplier setting divides the baud edges by exactly 1, 16, 32 or 64.

// File: rtl/brg_pkg.sv
package brg_pkg;
  localparam int unsigned REG_AW   = 4;
  localparam int unsigned REG_DW   = 8;
  localparam int unsigned TC_W     = 16;
  localparam int unsigned TC_BYTES = TC_W / REG_DW;

  localparam logic [REG_AW-1:0] A_STAT = 4'd0;
  localparam logic [REG_AW-1:0] A_MODE = 4'd4;
  localparam logic [REG_AW-1:0] A_TCLO = 4'd12;
  localparam logic [REG_AW-1:0] A_CTRL = 4'd14;
  localparam logic [REG_AW-1:0] A_IE   = 4'd15;

  localparam logic [2:0] CMD_CLR_STAT = 3'b010;

  typedef enum logic [1:0] {MUL_X1, MUL_X16, MUL_X32, MUL_X64} mul_e;

  typedef struct packed {
    logic [TC_W-1:0] tc;
    logic            run;
    logic            src_pclk;
    mul_e            mul;
    logic            timer_ie;
  } brg_cfg_t;
endpackage

// File: rtl/brg_regs.sv
module brg_regs
  import brg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic              zero_i,
  output logic [REG_DW-1:0] rdata_o,
  output brg_cfg_t          cfg_o,
  output logic              start_o,
  output logic              mode_wr_o,
  output logic              timer_stat_o
);
  logic [TC_BYTES-1:0][REG_DW-1:0] tc_q;
  logic [REG_DW-1:0] mode_q;
  logic run_q, src_q, ie_q, stat_q;
  logic stat_clr;

  for (genvar b = 0; b < TC_BYTES; b++) begin : g_tc_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tc_q[b] <= '0;
      else if (wr_en_i && addr_i == A_TCLO + REG_AW'(b)) tc_q[b] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      run_q  <= 1'b0;
      src_q  <= 1'b0;
      ie_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MODE: mode_q <= wdata_i;
        A_CTRL: begin
          run_q <= wdata_i[0];
          src_q <= wdata_i[1];
        end
        A_IE:   ie_q <= wdata_i[1];
        default: ;
      endcase
    end
  end

  assign stat_clr = wr_en_i && addr_i == A_STAT && wdata_i[5:3] == CMD_CLR_STAT;

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                stat_q <= 1'b0;
    else if (zero_i && ie_q)    stat_q <= 1'b1;
    else if (stat_clr)          stat_q <= 1'b0;
  end

  assign start_o   = wr_en_i && addr_i == A_CTRL && wdata_i[0] && !run_q;
  assign mode_wr_o = wr_en_i && addr_i == A_MODE;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STAT: rdata_o[1] = stat_q;
      A_MODE: rdata_o    = mode_q;
      A_CTRL: rdata_o    = {{(REG_DW-2){1'b0}}, src_q, run_q};
      A_IE:   rdata_o[1] = ie_q;
      default: begin
        for (int b = 0; b < TC_BYTES; b++)
          if (addr_i == A_TCLO + REG_AW'(b)) rdata_o = tc_q[b];
      end
    endcase
  end

  assign cfg_o.tc       = tc_q;
  assign cfg_o.run      = run_q;
  assign cfg_o.src_pclk = src_q;
  assign cfg_o.mul      = mul_e'(mode_q[7:6]);
  assign cfg_o.timer_ie = ie_q;
  assign timer_stat_o   = stat_q;
endmodule

// File: rtl/brg_src.sv
module brg_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_pclk_i,
  input  logic pclk_en_i,
  input  logic ext_clk_i,
  output logic tick_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign tick_o   = src_pclk_i ? pclk_en_i : ext_rise;
endmodule

// File: rtl/brg_counter.sv
module brg_counter #(
  parameter int unsigned TC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic            start_i,
  input  logic [TC_W-1:0] tc_i,
  output logic            baud_o,
  output logic            zero_o
);
  logic [TC_W-1:0] cnt_q;
  logic load_q, baud_q, zero_q;

  // half period: one reload tick, TC decrements, one terminal tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      load_q <= 1'b0;
      baud_q <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      zero_q <= 1'b0;
      if (start_i) begin
        load_q <= 1'b1;
      end else if (run_i && tick_i) begin
        if (load_q) begin
          cnt_q  <= tc_i;
          load_q <= 1'b0;
        end else if (cnt_q == '0) begin
          zero_q <= 1'b1;
          baud_q <= ~baud_q;
          load_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign baud_o = baud_q;
  assign zero_o = zero_q;
endmodule

// File: rtl/brg_mult.sv
module brg_mult
  import brg_pkg::*;
#(
  parameter int unsigned MAX_MUL = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic baud_i,
  input  logic zero_i,
  input  mul_e mul_i,
  input  logic clr_i,
  output logic bit_tick_o
);
  localparam int unsigned PRE_W = $clog2(MAX_MUL);

  logic [PRE_W-1:0] pre_q, lim;
  logic rise, tick_q;

  always_comb begin
    case (mul_i)
      MUL_X1:  lim = '0;
      MUL_X16: lim = PRE_W'(MAX_MUL / 4 - 1);
      MUL_X32: lim = PRE_W'(MAX_MUL / 2 - 1);
      default: lim = PRE_W'(MAX_MUL - 1);
    endcase
  end

  assign rise = zero_i & baud_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (clr_i) begin
        pre_q <= '0;
      end else if (rise) begin
        if (pre_q >= lim) begin
          pre_q  <= '0;
          tick_q <= 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  end

  assign bit_tick_o = tick_q;
endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import brg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_MUL     = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic              pclk_en_i,
  input  logic              ext_clk_i,
  output logic              baud_o,
  output logic              zero_o,
  output logic              bit_tick_o,
  output logic              timer_stat_o
);
  brg_cfg_t cfg;
  logic start, mode_wr, src_tick;
  logic cnt_en, timer_ie;

  assign cnt_en   = cfg.run;
  assign timer_ie = cfg.timer_ie;

  brg_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .zero_i(zero_o), .rdata_o, .cfg_o(cfg),
    .start_o(start), .mode_wr_o(mode_wr), .timer_stat_o
  );

  brg_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i, .rst_ni,
    .src_pclk_i(cfg.src_pclk), .pclk_en_i, .ext_clk_i,
    .tick_o(src_tick)
  );

  brg_counter #(.TC_W(TC_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i(src_tick), .run_i(cnt_en), .start_i(start), .tc_i(cfg.tc),
    .baud_o, .zero_o
  );

  brg_mult #(.MAX_MUL(MAX_MUL)) u_mult (
    .clk_i, .rst_ni,
    .baud_i(baud_o), .zero_i(zero_o), .mul_i(cfg.mul), .clr_i(mode_wr),
    .bit_tick_o
  );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic ie_i,
  input logic zero_i,
  input logic baud_i,
  input logic bit_tick_i,
  input logic stat_i
);
  AST_ZERO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> !zero_i); // R7
  AST_ZERO_WITH_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |-> baud_i != $past(baud_i)); // R7
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> $stable(baud_i)); // R4
  AST_NO_ZERO_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !zero_i); // R4
  AST_STAT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(zero_i && ie_i) |-> stat_i); // R8
  AST_TICK_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_i |-> $past(zero_i && baud_i)); // R9
endmodule

bind baud_gen baud_gen_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(cnt_en), .ie_i(timer_ie),
  .zero_i(zero_o), .baud_i(baud_o), .bit_tick_i(bit_tick_o), .stat_i(timer_stat_o)
);

// File: tb/baud_gen_tb.sv
`timescale 1ns/1ps
module baud_gen_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic pclk_en = 1'b0, ext_clk = 1'b0;
  logic baud, zero, bit_tick, tstat;

  int errors = 0, checks = 0;
  int half_q[$], btick_q[$];
  int cyc = 0, bcyc = 0, zero_cnt = 0, zrun = 0, zw_err = 0;
  int div = 1, div_cnt = 0, ext_half = 2, ext_cnt = 0;
  bit ext_on = 1'b0;
  logic prev_baud = 1'b0;

  always #2.5 clk = ~clk;

  baud_gen dut_i (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pclk_en_i(pclk_en), .ext_clk_i(ext_clk),
    .baud_o(baud), .zero_o(zero), .bit_tick_o(bit_tick), .timer_stat_o(tstat)
  );

  always @(negedge clk) begin
    if (div_cnt >= div - 1) begin pclk_en <= 1'b1; div_cnt <= 0; end
    else begin pclk_en <= 1'b0; div_cnt <= div_cnt + 1; end
    if (ext_on) begin
      if (ext_cnt >= ext_half - 1) begin ext_clk <= ~ext_clk; ext_cnt <= 0; end
      else ext_cnt <= ext_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++; bcyc++;
      if (baud !== prev_baud) begin half_q.push_back(cyc); cyc = 0; end
      prev_baud = baud;
      if (bit_tick) begin btick_q.push_back(bcyc); bcyc = 0; end
      if (zero) begin zero_cnt++; zrun++; if (zrun > 1) zw_err++; end
      else zrun = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_tc(input int tc);
    wr(4'd12, tc[7:0]); wr(4'd13, tc[15:8]);
  endtask

  task automatic wait_halves(input int n);
    while (half_q.size() < n) @(negedge clk);
  endtask

  function automatic int exp_half(input int tc, input int ticks);
    return (tc + 2) * ticks;
  endfunction

  function automatic int mul_of(input int m);
    return (m == 0) ? 1 : (m == 1) ? 16 : (m == 2) ? 32 : 64;
  endfunction

  task automatic measure(input string req, input int expv);
    half_q.delete();
    wait_halves(4);
    for (int i = 1; i < 4; i++) chk(half_q[i] == expv, req, half_q[i], expv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int tc, n, m;
    logic b0;
    void'($urandom(32'd5150));
    repeat (4) @(negedge clk);
    // R10 reset state
    foreach (m_addr[i]) ;
    chk(baud === 1'b0 && zero === 1'b0 && bit_tick === 1'b0 && tstat === 1'b0, "R10 outputs", baud, 0);
    rst_ni = 1'b1;
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], d);
      chk(d == 8'h00, "R10 reg", d, 0);
    end

    // R1 readback
    for (int i = 0; i < 4; i++) begin
      logic [7:0] v4, v12, v13, v14, v15;
      v4 = 8'($urandom); v12 = 8'($urandom); v13 = 8'($urandom);
      v14 = 8'($urandom) & 8'hFE; v15 = 8'($urandom);
      wr(4'd4, v4); wr(4'd12, v12); wr(4'd13, v13); wr(4'd14, v14); wr(4'd15, v15);
      rd(4'd4, d);  chk(d == v4, "R1 mode", d, v4);
      rd(4'd12, d); chk(d == v12, "R1 tc low", d, v12);
      rd(4'd13, d); chk(d == v13, "R1 tc high", d, v13);
      rd(4'd14, d); chk(d == (v14 & 8'h03), "R1 ctrl", d, v14 & 8'h03);
      rd(4'd15, d); chk(d == (v15 & 8'h02), "R1 ie", d, v15 & 8'h02);
    end
    wr(4'd14, 8'h00); wr(4'd15, 8'h00); wr(4'd4, 8'h00);

    // R5 first edge after enable, pclk strobe held high
    div = 1;
    for (int i = 0; i < 3; i++) begin
      tc = (i == 0) ? 5 : int'($urandom_range(0, 30));
      wr(4'd14, 8'h02); set_tc(tc);
      b0 = baud;
      @(negedge clk); wr_en = 1'b1; addr = 4'd14; wdata = 8'h03;
      @(negedge clk); wr_en = 1'b0;
      n = 0;
      while (baud === b0 && n < 1000) begin @(negedge clk); n++; end
      chk(n == tc + 2, "R5 first toggle", n, tc + 2);
    end

    // R2 half period from the strobe source, random constants and strobe rates
    for (int i = 0; i < 5; i++) begin
      tc = (i == 0) ? 0 : (i == 1) ? 256 : int'($urandom_range(1, 25));
      div = (i < 2) ? 1 : int'($urandom_range(1, 4));
      wr(4'd14, 8'h02); set_tc(tc); wr(4'd14, 8'h03);
      measure("R2 half period", exp_half(tc, div));
    end

    // R3 external clock source
    div = 1;
    for (int i = 0; i < 3; i++) begin
      tc = int'($urandom_range(0, 12));
      ext_half = int'($urandom_range(2, 5));
      ext_on = 1'b1;
      wr(4'd14, 8'h00); set_tc(tc); wr(4'd14, 8'h01);
      measure("R3 ext half period", exp_half(tc, 2 * ext_half));
    end
    ext_on = 1'b0;

    // R6 time constant changed mid-count
    div = 1;
    wr(4'd14, 8'h02); set_tc(20); wr(4'd14, 8'h03);
    wait_halves(1);
    half_q.delete();
    wait_halves(1);
    set_tc(7);
    wait_halves(3);
    chk(half_q[1] == exp_half(20, 1), "R6 current half keeps old", half_q[1], exp_half(20, 1));
    chk(half_q[2] == exp_half(7, 1), "R6 next half uses new", half_q[2], exp_half(7, 1));

    // R7 zero pulse per toggle, single cycle
    half_q.delete(); zero_cnt = 0; zw_err = 0;
    wait_halves(8);
    @(negedge clk);
    chk(zero_cnt == half_q.size(), "R7 pulse per toggle", zero_cnt, half_q.size());
    chk(zw_err == 0, "R7 pulse width", zw_err, 0);

    // R4 hold while stopped
    wr(4'd14, 8'h02);
    b0 = baud; zero_cnt = 0; half_q.delete();
    repeat (200) @(negedge clk);
    chk(baud === b0 && half_q.size() == 0, "R4 baud static", baud, b0);
    chk(zero_cnt == 0, "R4 no zero pulse", zero_cnt, 0);

    // R8 timer status latch
    wr(4'd15, 8'h02); set_tc(3); wr(4'd14, 8'h03);
    half_q.delete(); wait_halves(2);
    rd(4'd0, d); chk(d[1] == 1'b1, "R8 status set", d[1], 1);
    wr(4'd14, 8'h02);
    repeat (3) @(negedge clk);
    rd(4'd0, d); chk(d[1] == 1'b1, "R8 status holds", d[1], 1);
    wr(4'd0, 8'h10);
    rd(4'd0, d); chk(d[1] == 1'b0 && tstat == 1'b0, "R8 status cleared", d[1], 0);
    wr(4'd15, 8'h00); wr(4'd14, 8'h03);
    half_q.delete(); wait_halves(4);
    rd(4'd0, d); chk(d[1] == 1'b0, "R8 masked", d[1], 0);

    // R9 multiplier
    for (m = 0; m < 4; m++) begin
      tc = int'($urandom_range(0, 2));
      wr(4'd14, 8'h02); set_tc(tc); wr(4'd4, {m[1:0], 6'h15}); wr(4'd14, 8'h03);
      btick_q.delete();
      while (btick_q.size() < 3) @(negedge clk);
      for (int i = 1; i < 3; i++)
        chk(btick_q[i] == mul_of(m) * 2 * exp_half(tc, 1), "R9 bit tick spacing",
            btick_q[i], mul_of(m) * 2 * exp_half(tc, 1));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int m_addr[1];
endmodule